// File: doc/BRIEF.md
# Interrupt Redirection Router

This block sits between a large set of interrupt sources and the hardware threads of a multi-node processor. Each source owns one entry of a programmable redirection table. The entry decides whether the source is live, which 6-bit vector it raises, whether it is a non-maskable interrupt, and which threads receive it. The threads are numbered flatly as node*32 + core*4 + thread, which gives 128 destinations over four nodes.

An entry names its targets in one of two ways. In direct mode it picks a node and one half of that node's cores, and then a 16-bit thread mask inside that half. In group mode it points at one of eight shared thread-enable groups, and each group holds a full 32-bit mask for every node. The entry can broadcast to every target, or it can hand the interrupt to a single target chosen in rotation. Once a source is delivered it stays in service until software writes its index to the acknowledge port. The twelve lowest sources are the timer and watchdog events. Each of these also holds a sticky status bit, which software must clear as well.

Top module: `irt_router`

## Requirements
- R1: After reset, every table entry is disabled, every group mask is zero, the status bits are zero, and `dlv_valid` and `dlv_strobe` are low.
- R2: A source pulse that arrives while its entry enable (bit 31) is 0 is dropped. Enabling the entry later produces no delivery.
- R3: In direct mode (entry bit 19 = 1), node = bits 18:17 and core half = bit 16, where 0 means cores 0-3 and 1 means cores 4-7. Mask bit j (bits 15:0) targets thread node*32 + half*16 + j.
- R4: In group mode (entry bit 19 = 0), bits 18:16 select a group and the entry's mask field is ignored. A group write with `grp_hi`=0 loads node0 from data bits 31:0 and node1 from bits 63:32. With `grp_hi`=1 it loads node2 and node3 in the same way. The target set is the group's 128-bit mask.
- R5: A delivery carries the vector from entry bits 25:20 on `dlv_vec`, the NMI flag from bit 29 on `dlv_nmi`, and the source index on `dlv_src`.
- R6: A source pulse driven in cycle k gives a delivery whose strobe is high for exactly one cycle, in cycle k+2. `dlv_strobe` is zero whenever `dlv_valid` is low.
- R7: A delivered source is not delivered again until its index has been acknowledged. A pulse that arrives while the source is in service stays pending. The source is then delivered two cycles after the acknowledge write.
- R8: When several eligible sources are pending, the lowest index is delivered first, one source per cycle.
- R9: With scheduling bit 28 = 1, every target thread is strobed. With bit 28 = 0, exactly one target is strobed: the first set thread at or after a rotating pointer, wrapping at 128. After each such delivery the pointer moves to the chosen thread + 1. The pointer is 0 after reset.
- R10: Delivering a source with index below 12 sets status bit `stat_o[index]`, and the bit stays set until a 1 is written to `stat_clr` at that position. Such a source is eligible only when it has been acknowledged and its status bit is clear. Sources at index 12 and above never touch the status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Interrupt source requests, sampled every cycle |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_idx | input | IDX_W | Entry index to write |
| tbl_wdata | input | 32 | Entry word |
| grp_we | input | 1 | Group mask write strobe |
| grp_sel | input | 3 | Group number |
| grp_hi | input | 1 | 0: nodes 0/1, 1: nodes 2/3 |
| grp_wdata | input | 64 | Two 32-bit node masks |
| ack_we | input | 1 | Acknowledge write strobe |
| ack_idx | input | IDX_W | Index being acknowledged |
| stat_clr | input | NUM_STAT | Write-one-to-clear for the status bits |
| dlv_valid | output | 1 | A delivery happens this cycle |
| dlv_strobe | output | 128 | Per-thread delivery strobes |
| dlv_vec | output | 6 | Delivered vector |
| dlv_nmi | output | 1 | Delivered NMI flag |
| dlv_src | output | IDX_W | Delivered source index |
| stat_o | output | NUM_STAT | Sticky status bits of the low sources |

## Verification
The assertions assume that `ack_idx` names only sources that are actually in service. They also assume that `stat_clr` never clears a bit in the same cycle that a matching low source could be granted, which holds because a set status bit blocks the grant. The stimulus uses single-cycle source pulses only and acknowledges each delivery before it pulses that source again, except where it deliberately tests the in-service hold. Table and group writes are made while the affected sources are idle, so no delivery ever reads an entry that is being changed.

// File: rtl/irt_router_pkg.sv
package irt_router_pkg;

    localparam int VEC_W        = 6;
    localparam int WORD_W       = 32;
    localparam int NODES        = 4;
    localparam int THR_PER_NODE = 32;
    localparam int NUM_THR      = NODES * THR_PER_NODE;
    localparam int THR_W        = $clog2(NUM_THR);
    localparam int HALF_W       = 16;
    localparam int GROUPS       = 8;
    localparam int BASE_W       = 3;
    localparam int GRP_W        = $clog2(GROUPS);
    localparam int PAIR_W       = 2 * THR_PER_NODE;

    typedef enum logic {
        DEST_GROUP  = 1'b0,
        DEST_DIRECT = 1'b1
    } dest_mode_e;

    typedef struct packed {
        logic              en;
        logic              nmi;
        logic              sch;
        logic [VEC_W-1:0]  vec;
        dest_mode_e        mode;
        logic [BASE_W-1:0] base;
        logic [HALF_W-1:0] mask;
    } irt_entry_t;

    function automatic irt_entry_t unpack_entry(input logic [WORD_W-1:0] w);
        irt_entry_t e;
        e.en   = w[31];
        e.nmi  = w[29];
        e.sch  = w[28];
        e.vec  = w[25:20];
        e.mode = dest_mode_e'(w[19]);
        e.base = w[18:16];
        e.mask = w[15:0];
        return e;
    endfunction

    function automatic logic [NUM_THR-1:0] direct_targets(
        input logic [BASE_W-1:0] base,
        input logic [HALF_W-1:0] mask
    );
        logic [NUM_THR-1:0] t;
        logic [THR_W-1:0]   start;
        t     = '0;
        start = {base[2:1], base[0], 4'b0000};
        t[start +: HALF_W] = mask;
        return t;
    endfunction

endpackage

// File: rtl/irt_table.sv
module irt_table
    import irt_router_pkg::*;
#(
    parameter int NUM_SRC = 160,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tbl_we,
    input  logic [IDX_W-1:0]      tbl_idx,
    input  logic [WORD_W-1:0]     tbl_wdata,
    input  logic                  grp_we,
    input  logic [GRP_W-1:0]      grp_sel,
    input  logic                  grp_hi,
    input  logic [PAIR_W-1:0]     grp_wdata,
    input  logic [IDX_W-1:0]      rd_idx,
    output irt_entry_t            rd_entry,
    output logic [NUM_THR-1:0]    rd_group,
    output logic [NUM_SRC-1:0]    en_vec
);

    irt_entry_t         tbl_q [NUM_SRC];
    logic [NUM_THR-1:0] grp_q [GROUPS];

    logic unused_rsv_bits;
    assign unused_rsv_bits = ^{tbl_wdata[30], tbl_wdata[27:26]};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SRC; i++) tbl_q[i] <= '0;
        end else if (tbl_we && (32'(tbl_idx) < NUM_SRC)) begin
            tbl_q[tbl_idx] <= unpack_entry(tbl_wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int g = 0; g < GROUPS; g++) grp_q[g] <= '0;
        end else if (grp_we) begin
            if (grp_hi) grp_q[grp_sel][NUM_THR-1:PAIR_W] <= grp_wdata;
            else        grp_q[grp_sel][PAIR_W-1:0]       <= grp_wdata;
        end
    end

    generate
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_en
            assign en_vec[s] = tbl_q[s].en;
        end
    endgenerate

    always_comb begin
        rd_entry = tbl_q[rd_idx];
        rd_group = grp_q[rd_entry.base];
    end

endmodule

// File: rtl/irt_arbiter.sv
module irt_arbiter #(
    parameter int NUM_SRC  = 160,
    parameter int NUM_STAT = 12,
    parameter int IDX_W    = $clog2(NUM_SRC)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  src_i,
    input  logic [NUM_SRC-1:0]  en_vec,
    input  logic                ack_we,
    input  logic [IDX_W-1:0]    ack_idx,
    input  logic [NUM_STAT-1:0] stat_clr,
    output logic                gnt_valid,
    output logic [IDX_W-1:0]    gnt_idx,
    output logic [NUM_STAT-1:0] stat_o
);

    localparam logic [NUM_SRC-1:0] ONE = {{(NUM_SRC-1){1'b0}}, 1'b1};

    logic [NUM_SRC-1:0]  pend_q, busy_q;
    logic [NUM_STAT-1:0] stat_q;
    logic [NUM_SRC-1:0]  stat_ext, elig, gnt_vec, ack_vec;

    always_comb begin
        stat_ext                 = '0;
        stat_ext[NUM_STAT-1:0]   = stat_q;
        elig                     = pend_q & en_vec & ~busy_q & ~stat_ext;
    end

    // fixed priority: lowest index wins
    always_comb begin
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (elig[i]) begin
                gnt_valid = 1'b1;
                gnt_idx   = IDX_W'(i);
            end
        end
    end

    assign gnt_vec = gnt_valid ? (ONE << gnt_idx) : '0;
    assign ack_vec = ack_we    ? (ONE << ack_idx) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            busy_q <= '0;
            stat_q <= '0;
        end else begin
            pend_q <= ((pend_q & ~gnt_vec) | src_i) & en_vec;
            busy_q <= (busy_q & ~ack_vec) | gnt_vec;
            stat_q <= (stat_q & ~stat_clr) | gnt_vec[NUM_STAT-1:0];
        end
    end

    assign stat_o = stat_q;

endmodule

// File: rtl/irt_steer.sv
module irt_steer
    import irt_router_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               gnt_valid,
    input  logic [IDX_W-1:0]   gnt_idx,
    input  irt_entry_t         entry,
    input  logic [NUM_THR-1:0] group_mask,
    output logic               dlv_valid,
    output logic [NUM_THR-1:0] dlv_strobe,
    output logic [VEC_W-1:0]   dlv_vec,
    output logic               dlv_nmi,
    output logic [IDX_W-1:0]   dlv_src,
    output logic               dlv_bcast
);

    localparam logic [NUM_THR-1:0] ONE_T = {{(NUM_THR-1){1'b0}}, 1'b1};

    logic [THR_W-1:0]   ptr_q;
    logic [NUM_THR-1:0] targets, sel;
    logic [THR_W-1:0]   pick, probe;
    logic               found;

    logic unused_entry_en;
    assign unused_entry_en = entry.en;

    always_comb begin
        if (entry.mode == DEST_DIRECT) targets = direct_targets(entry.base, entry.mask);
        else                           targets = group_mask;
    end

    // rotating pick: first set target at or after the pointer
    always_comb begin
        found = 1'b0;
        pick  = '0;
        probe = '0;
        for (int i = 0; i < NUM_THR; i++) begin
            probe = ptr_q + THR_W'(i);
            if (!found && targets[probe]) begin
                found = 1'b1;
                pick  = probe;
            end
        end
        if (entry.sch)  sel = targets;
        else if (found) sel = ONE_T << pick;
        else            sel = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dlv_valid  <= 1'b0;
            dlv_strobe <= '0;
            dlv_vec    <= '0;
            dlv_nmi    <= 1'b0;
            dlv_src    <= '0;
            dlv_bcast  <= 1'b0;
            ptr_q      <= '0;
        end else begin
            dlv_valid  <= gnt_valid;
            dlv_strobe <= gnt_valid ? sel : '0;
            dlv_vec    <= gnt_valid ? entry.vec : '0;
            dlv_nmi    <= gnt_valid & entry.nmi;
            dlv_src    <= gnt_valid ? gnt_idx : '0;
            dlv_bcast  <= gnt_valid & entry.sch;
            if (gnt_valid && !entry.sch && found) ptr_q <= pick + THR_W'(1);
        end
    end

endmodule

// File: rtl/irt_router.sv
module irt_router
    import irt_router_pkg::*;
#(
    parameter int NUM_SRC  = 160,
    parameter int NUM_STAT = 12,
    parameter int IDX_W    = $clog2(NUM_SRC)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  src_i,
    input  logic                tbl_we,
    input  logic [IDX_W-1:0]    tbl_idx,
    input  logic [31:0]         tbl_wdata,
    input  logic                grp_we,
    input  logic [2:0]          grp_sel,
    input  logic                grp_hi,
    input  logic [63:0]         grp_wdata,
    input  logic                ack_we,
    input  logic [IDX_W-1:0]    ack_idx,
    input  logic [NUM_STAT-1:0] stat_clr,
    output logic                dlv_valid,
    output logic [127:0]        dlv_strobe,
    output logic [5:0]          dlv_vec,
    output logic                dlv_nmi,
    output logic [IDX_W-1:0]    dlv_src,
    output logic [NUM_STAT-1:0] stat_o
);

    logic               gnt_valid;
    logic [IDX_W-1:0]   gnt_idx;
    irt_entry_t         cur_entry;
    logic [NUM_THR-1:0] cur_group;
    logic [NUM_SRC-1:0] en_vec;
    logic               bcast;

    irt_table #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_table (
        .clk       (clk),
        .rst       (rst),
        .tbl_we    (tbl_we),
        .tbl_idx   (tbl_idx),
        .tbl_wdata (tbl_wdata),
        .grp_we    (grp_we),
        .grp_sel   (grp_sel),
        .grp_hi    (grp_hi),
        .grp_wdata (grp_wdata),
        .rd_idx    (gnt_idx),
        .rd_entry  (cur_entry),
        .rd_group  (cur_group),
        .en_vec    (en_vec)
    );

    irt_arbiter #(.NUM_SRC(NUM_SRC), .NUM_STAT(NUM_STAT), .IDX_W(IDX_W)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .src_i     (src_i),
        .en_vec    (en_vec),
        .ack_we    (ack_we),
        .ack_idx   (ack_idx),
        .stat_clr  (stat_clr),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx),
        .stat_o    (stat_o)
    );

    irt_steer #(.IDX_W(IDX_W)) u_steer (
        .clk        (clk),
        .rst        (rst),
        .gnt_valid  (gnt_valid),
        .gnt_idx    (gnt_idx),
        .entry      (cur_entry),
        .group_mask (cur_group),
        .dlv_valid  (dlv_valid),
        .dlv_strobe (dlv_strobe),
        .dlv_vec    (dlv_vec),
        .dlv_nmi    (dlv_nmi),
        .dlv_src    (dlv_src),
        .dlv_bcast  (bcast)
    );

endmodule

// File: rtl/irt_router_checker.sv
module irt_router_checker #(
    parameter int NUM_SRC  = 160,
    parameter int NUM_STAT = 12,
    parameter int IDX_W    = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                dlv_valid,
    input logic [127:0]        dlv_strobe,
    input logic [IDX_W-1:0]    dlv_src,
    input logic                dlv_bcast,
    input logic [NUM_SRC-1:0]  en_vec,
    input logic [NUM_STAT-1:0] stat_o,
    input logic [NUM_STAT-1:0] stat_clr
);

    logic [NUM_SRC-1:0] en_q;
    always_ff @(posedge clk) begin
        if (rst) en_q <= '0;
        else     en_q <= en_vec;
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!dlv_valid && dlv_strobe == '0)); // R1

    AST_ENABLED_ONLY: assert property (@(posedge clk) disable iff (rst)
        dlv_valid |-> (((en_q >> dlv_src) & {{(NUM_SRC-1){1'b0}}, 1'b1}) != '0)); // R2

    AST_STROBE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        !dlv_valid |-> (dlv_strobe == '0)); // R6

    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        dlv_valid |=> !(dlv_valid && dlv_src == $past(dlv_src))); // R7

    AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (rst)
        (dlv_valid && !dlv_bcast) |-> ($countones(dlv_strobe) <= 1)); // R9

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
        ($past(stat_o) & ~stat_o & ~$past(stat_clr)) == '0); // R10

    AST_LOW_SETS_STATUS: assert property (@(posedge clk) disable iff (rst)
        (dlv_valid && 32'(dlv_src) < NUM_STAT) |->
            (((stat_o >> dlv_src) & {{(NUM_STAT-1){1'b0}}, 1'b1}) != '0)); // R10

endmodule

bind irt_router irt_router_checker #(
    .NUM_SRC  (NUM_SRC),
    .NUM_STAT (NUM_STAT),
    .IDX_W    (IDX_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .dlv_valid  (dlv_valid),
    .dlv_strobe (dlv_strobe),
    .dlv_src    (dlv_src),
    .dlv_bcast  (bcast),
    .en_vec     (en_vec),
    .stat_o     (stat_o),
    .stat_clr   (stat_clr)
);

// File: tb/irt_router_bench.sv
module irt_router_bench;

    localparam int NSRC  = 160;
    localparam int NSTAT = 12;
    localparam int IW    = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NSRC-1:0]   src_i = '0;
    logic              tbl_we = 1'b0;
    logic [IW-1:0]     tbl_idx = '0;
    logic [31:0]       tbl_wdata = '0;
    logic              grp_we = 1'b0;
    logic [2:0]        grp_sel = '0;
    logic              grp_hi = 1'b0;
    logic [63:0]       grp_wdata = '0;
    logic              ack_we = 1'b0;
    logic [IW-1:0]     ack_idx = '0;
    logic [NSTAT-1:0]  stat_clr = '0;
    logic              dlv_valid;
    logic [127:0]      dlv_strobe;
    logic [5:0]        dlv_vec;
    logic              dlv_nmi;
    logic [IW-1:0]     dlv_src;
    logic [NSTAT-1:0]  stat_o;

    irt_router #(.NUM_SRC(NSRC), .NUM_STAT(NSTAT), .IDX_W(IW)) u_irt_router (
        .clk(clk), .rst(rst), .src_i(src_i),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_wdata(tbl_wdata),
        .grp_we(grp_we), .grp_sel(grp_sel), .grp_hi(grp_hi), .grp_wdata(grp_wdata),
        .ack_we(ack_we), .ack_idx(ack_idx), .stat_clr(stat_clr),
        .dlv_valid(dlv_valid), .dlv_strobe(dlv_strobe), .dlv_vec(dlv_vec),
        .dlv_nmi(dlv_nmi), .dlv_src(dlv_src), .stat_o(stat_o)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int           src;
        logic [5:0]   vec;
        logic         nmi;
        logic [127:0] mask;
        int           due;
        string        req;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_err = 0;
    int   seen  = 0;
    int   rr_ptr = 0;
    bit   done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // monitor: pops expected deliveries and compares
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (dlv_valid) begin
                seen++;
                if (exp_q.size() == 0) begin
                    chk(0, "R7", "unexpected delivery src", 128'(dlv_src), 128'hFFFF);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(32'(dlv_src) == e.src, e.req, "src", 128'(dlv_src), 128'(e.src));
                    chk(dlv_strobe == e.mask, e.req, "strobe", dlv_strobe, e.mask);
                    chk(dlv_vec == e.vec && dlv_nmi == e.nmi, "R5", "vec/nmi",
                        128'({dlv_nmi, dlv_vec}), 128'({e.nmi, e.vec}));
                    chk(cyc == e.due, "R6", "delivery cycle", 128'(cyc), 128'(e.due));
                end
            end else if (dlv_strobe != '0) begin
                chk(0, "R6", "strobe without valid", dlv_strobe, 128'h0);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] mk_entry(input bit en, input bit nmi, input bit sch,
        input logic [5:0] vec, input bit direct, input logic [2:0] base, input logic [15:0] mask);
        return {en, 1'b0, nmi, sch, 2'b00, vec, direct, base, mask};
    endfunction

    function automatic logic [127:0] direct_mask(input logic [2:0] base, input logic [15:0] m);
        logic [127:0] r;
        int node, half;
        r = '0;
        node = int'(base) / 2;
        half = int'(base) % 2;
        for (int j = 0; j < 16; j++) if (m[j]) r[node * 32 + half * 16 + j] = 1'b1;
        return r;
    endfunction

    function automatic logic [127:0] rr_take(input logic [127:0] m);
        logic [127:0] r;
        r = '0;
        for (int i = 0; i < 128; i++) begin
            int t;
            t = (rr_ptr + i) % 128;
            if (m[t]) begin
                r[t] = 1'b1;
                rr_ptr = (t + 1) % 128;
                return r;
            end
        end
        return r;
    endfunction

    task automatic write_entry(input int idx, input logic [31:0] w);
        tbl_we = 1'b1; tbl_idx = IW'(idx); tbl_wdata = w;
        tick(1);
        tbl_we = 1'b0;
    endtask

    task automatic write_group(input int g, input bit hi, input logic [63:0] d);
        grp_we = 1'b1; grp_sel = 3'(g); grp_hi = hi; grp_wdata = d;
        tick(1);
        grp_we = 1'b0;
    endtask

    task automatic pulse(input int idx, output int k);
        k = cyc;
        src_i[idx] = 1'b1;
        tick(1);
        src_i[idx] = 1'b0;
    endtask

    task automatic ack(input int idx, output int k);
        k = cyc;
        ack_we = 1'b1; ack_idx = IW'(idx);
        tick(1);
        ack_we = 1'b0;
    endtask

    task automatic expect_dlv(input int src, input logic [5:0] vec, input bit nmi,
                              input logic [127:0] mask, input int due, input string req);
        exp_t e;
        e.src = src; e.vec = vec; e.nmi = nmi; e.mask = mask; e.due = due; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        finish_run();
    end

    initial begin
        int k, s0;
        logic [127:0] m;
        tick(3);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(dlv_valid == 1'b0, "R1", "valid after reset", 128'(dlv_valid), 128'h0);
        chk(dlv_strobe == '0, "R1", "strobe after reset", dlv_strobe, 128'h0);
        chk(stat_o == '0, "R1", "status after reset", 128'(stat_o), 128'h0);
        tick(1);

        // R3: direct mode broadcast, node1 upper half
        write_entry(20, mk_entry(1, 0, 1, 6'h15, 1, 3'b011, 16'h8001));
        pulse(20, k);
        expect_dlv(20, 6'h15, 0, direct_mask(3'b011, 16'h8001), k + 2, "R3");
        tick(4);
        chk(stat_o == '0, "R10", "high index leaves status", 128'(stat_o), 128'h0);
        ack(20, k);

        // R2: disabled source is dropped and forgotten
        s0 = seen;
        pulse(30, k);
        tick(3);
        write_entry(30, mk_entry(1, 0, 1, 6'h01, 1, 3'b000, 16'h0001));
        tick(6);
        chk(seen == s0, "R2", "deliveries from disabled source", 128'(seen - s0), 128'h0);

        // R4: group mode, entry mask ignored
        write_group(5, 0, {32'h0000_0100, 32'h0000_0003});
        write_group(5, 1, {32'h8000_0000, 32'h0000_0000});
        write_entry(40, mk_entry(1, 1, 1, 6'h3F, 0, 3'd5, 16'hFFFF));
        pulse(40, k);
        m = 128'h8000_0000_0000_0000_0000_0100_0000_0003;
        expect_dlv(40, 6'h3F, 1, m, k + 2, "R4");
        tick(4);

        // R7: held in service until acknowledged, then pending pulse delivered
        s0 = seen;
        pulse(40, k);
        tick(6);
        chk(seen == s0, "R7", "redelivery while in service", 128'(seen - s0), 128'h0);
        ack(40, k);
        expect_dlv(40, 6'h3F, 1, m, k + 2, "R7");
        tick(4);
        ack(40, k);

        // R8: lowest index first
        write_entry(50, mk_entry(1, 0, 1, 6'h07, 1, 3'b100, 16'h0F00));
        write_entry(60, mk_entry(1, 1, 1, 6'h09, 1, 3'b110, 16'h0001));
        k = cyc;
        src_i[50] = 1'b1; src_i[60] = 1'b1;
        tick(1);
        src_i[50] = 1'b0; src_i[60] = 1'b0;
        expect_dlv(50, 6'h07, 0, direct_mask(3'b100, 16'h0F00), k + 2, "R8");
        expect_dlv(60, 6'h09, 1, direct_mask(3'b110, 16'h0001), k + 3, "R8");
        tick(5);
        ack(50, k);
        ack(60, k);

        // R9: single-target rotation over threads 0,1,5
        write_entry(70, mk_entry(1, 0, 0, 6'h22, 1, 3'b000, 16'h0023));
        for (int r = 0; r < 4; r++) begin
            pulse(70, k);
            expect_dlv(70, 6'h22, 0, rr_take(direct_mask(3'b000, 16'h0023)), k + 2, "R9");
            tick(4);
            ack(70, k);
        end

        // R10: low index needs both acknowledge and status clear
        write_entry(4, mk_entry(1, 0, 1, 6'h04, 1, 3'b000, 16'h0001));
        pulse(4, k);
        expect_dlv(4, 6'h04, 0, direct_mask(3'b000, 16'h0001), k + 2, "R10");
        tick(4);
        chk(stat_o == 12'h010, "R10", "status set by delivery", 128'(stat_o), 128'h010);
        ack(4, k);
        s0 = seen;
        pulse(4, k);
        tick(6);
        chk(seen == s0, "R10", "delivery while status set", 128'(seen - s0), 128'h0);
        chk(stat_o == 12'h010, "R10", "status sticky", 128'(stat_o), 128'h010);
        k = cyc;
        stat_clr = 12'h010;
        expect_dlv(4, 6'h04, 0, direct_mask(3'b000, 16'h0001), k + 2, "R10");
        tick(1);
        stat_clr = '0;
        @(negedge clk);
        chk(stat_o == 12'h000, "R10", "status cleared", 128'(stat_o), 128'h0);
        tick(4);
        chk(stat_o == 12'h010, "R10", "status set again", 128'(stat_o), 128'h010);

        tick(3);
        chk(exp_q.size() == 0, "R6", "outstanding expected deliveries",
            128'(exp_q.size()), 128'h0);
        finish_run();
    end

endmodule